// File: doc/BRIEF.md
# Merged Program/Data Chip-Enable Decoder

This block turns a 24-bit external bus address into active-low chip enables for two families of memory region. Data accesses land in one of eight equal data regions of 2 MB each, picked by the top three address bits. Program fetches land in one of four program regions of 1 MB each, picked by the top four address bits. Together the four program regions cover the lowest 4 MB of the space.

Each data region has its own merge bit. When a region's merge bit is set, that region also answers instruction fetches. A program fetch whose address falls in a merged region drives that region's data enable and no program enable. In this way one memory device can hold both code and data. The merge bits are held in a register and cleared by reset.

Requests come with a valid strobe. There is no back-pressure: the decoder accepts every request on every clock. The enables are registered, so the enables for a request presented in one cycle appear after the next rising edge.

Top module: `cedec_top`

## Requirements
- R1: A valid data access (fetch qualifier low) with address bits [23:21] equal to n drives data enable n low one clock later. Bit n of the data-enable output belongs to region n.
- R2: A valid program fetch to a region whose merge bit is clear, with address bits [23:20] equal to m and m < 4, drives program enable m low one clock later. Bit m of the program-enable output belongs to program region m.
- R3: A valid program fetch to a region whose merge bit is clear, with address bits [23:20] of 4 or more, drives no enable.
- R4: A valid program fetch whose address bits [23:21] select a region with its merge bit set drives that region's data enable low and leaves every program enable high.
- R5: When the valid strobe is low, every enable is high one clock later.
- R6: At no time is more than one enable low.
- R7: Reset drives every enable high and clears every merge bit. After reset, a fetch to address 0 selects program enable 0.
- R8: When the configuration write strobe is high at a rising edge, the merge bits load from the configuration input (bit n belongs to data region n). The new value first applies to requests presented in the following cycle.
- R9: The merge bits have no effect on data accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_fetch_i | input | 1 | 1 = program fetch, 0 = data access |
| req_addr_i | input | 24 | Byte address |
| cfg_wr_i | input | 1 | Load strobe for the merge bits |
| cfg_merge_i | input | 8 | New merge bits, bit n for data region n |
| ce_n_o | output | 8 | Data-region enables, active low |
| pce_n_o | output | 4 | Program-region enables, active low |

## Verification
The hardest case to reach from the ports is the interaction between a merge write and a fetch presented in the same cycle. The fetch must still decode with the old merge bits, and the fetch in the next cycle must use the new ones. The stimulus covers this with a directed pass that toggles merge bits for regions 0 and 1 while it issues fetches below 4 MB, so each write changes which family of enable answers. A long random pass then mixes writes, fetches and data accesses in every cycle.

// File: rtl/cedec_pkg.sv
package cedec_pkg;
  localparam int unsigned ADDR_W     = 24;
  localparam int unsigned N_DATA     = 8;
  localparam int unsigned N_PROG     = 4;
  localparam int unsigned DATA_SHIFT = 21;
  localparam int unsigned PROG_SHIFT = 20;
  localparam int unsigned DSEL_W     = ADDR_W - DATA_SHIFT;
  localparam int unsigned PSEL_W     = ADDR_W - PROG_SHIFT;

  typedef struct packed {
    logic              valid;
    logic              fetch;
    logic [ADDR_W-1:0] addr;
  } bus_req_t;
endpackage

// File: rtl/cedec_merge_reg.sv
module cedec_merge_reg #(
  parameter int unsigned N = cedec_pkg::N_DATA
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] merge_o
);
  logic [N-1:0] merge_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   merge_q <= '0;
    else if (wr_i) merge_q <= wdata_i;
  end

  assign merge_o = merge_q;

  // p_cfg_hold_r8: without a write strobe the merge bits keep their value
  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(wr_i) |-> $stable(merge_q));
endmodule

// File: rtl/cedec_data_dec.sv
module cedec_data_dec
  import cedec_pkg::*;
#(
  parameter int unsigned N     = N_DATA,
  parameter int unsigned SHIFT = DATA_SHIFT
) (
  input  bus_req_t     req_i,
  input  logic [N-1:0] merge_i,
  output logic [N-1:0] hit_o,
  output logic         merged_fetch_o
);
  localparam int unsigned SW = ADDR_W - SHIFT;

  logic [SW-1:0] sel;
  assign sel = req_i.addr[ADDR_W-1:SHIFT];

  for (genvar n = 0; n < N; n++) begin : g_region
    logic match;
    assign match    = (sel == SW'(n));
    assign hit_o[n] = req_i.valid && match && (!req_i.fetch || merge_i[n]);
  end

  always_comb begin
    merged_fetch_o = 1'b0;
    for (int n = 0; n < N; n++)
      if (sel == SW'(n) && merge_i[n]) merged_fetch_o = req_i.valid && req_i.fetch;
  end
endmodule

// File: rtl/cedec_prog_dec.sv
module cedec_prog_dec
  import cedec_pkg::*;
#(
  parameter int unsigned M     = N_PROG,
  parameter int unsigned SHIFT = PROG_SHIFT
) (
  input  bus_req_t     req_i,
  input  logic         merged_i,
  output logic [M-1:0] hit_o
);
  localparam int unsigned SW = ADDR_W - SHIFT;

  logic [SW-1:0] sel;
  logic          fetch_ok;
  assign sel      = req_i.addr[ADDR_W-1:SHIFT];
  assign fetch_ok = req_i.valid && req_i.fetch && !merged_i;

  for (genvar m = 0; m < M; m++) begin : g_prog
    assign hit_o[m] = fetch_ok && (sel == SW'(m));
  end
endmodule

// File: rtl/cedec_top.sv
module cedec_top
  import cedec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_fetch_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              cfg_wr_i,
  input  logic [N_DATA-1:0] cfg_merge_i,
  output logic [N_DATA-1:0] ce_n_o,
  output logic [N_PROG-1:0] pce_n_o
);
  bus_req_t          req;
  logic [N_DATA-1:0] merge, data_hit;
  logic [N_PROG-1:0] prog_hit;
  logic              merged_fetch;
  logic [N_DATA-1:0] ce_n_q;
  logic [N_PROG-1:0] pce_n_q;

  assign req = '{valid: req_valid_i, fetch: req_fetch_i, addr: req_addr_i};

  cedec_merge_reg #(.N(N_DATA)) u_merge (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(cfg_wr_i),
    .wdata_i(cfg_merge_i), .merge_o(merge)
  );

  cedec_data_dec #(.N(N_DATA), .SHIFT(DATA_SHIFT)) u_data (
    .req_i(req), .merge_i(merge), .hit_o(data_hit), .merged_fetch_o(merged_fetch)
  );

  cedec_prog_dec #(.M(N_PROG), .SHIFT(PROG_SHIFT)) u_prog (
    .req_i(req), .merged_i(merged_fetch), .hit_o(prog_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_q  <= '1;
      pce_n_q <= '1;
    end else begin
      ce_n_q  <= ~data_hit;
      pce_n_q <= ~prog_hit;
    end
  end

  assign ce_n_o  = ce_n_q;
  assign pce_n_o = pce_n_q;

  // p_single_enable_r6
  p_single_enable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~ce_n_o, ~pce_n_o}) <= 1);

  // p_idle_quiet_r5
  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(req_valid_i) |-> (&ce_n_o && &pce_n_o));

  // p_data_select_r1 (also R9: independent of merge bits)
  p_data_select_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(req_valid_i) && !$past(req_fetch_i)
    |-> (ce_n_o[$past(req_addr_i[ADDR_W-1:DATA_SHIFT])] == 1'b0 && &pce_n_o));

  // p_merged_fetch_r4
  p_merged_fetch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(req_valid_i) && $past(req_fetch_i)
    && $past(merge[req_addr_i[ADDR_W-1:DATA_SHIFT]])
    |-> (&pce_n_o && ce_n_o[$past(req_addr_i[ADDR_W-1:DATA_SHIFT])] == 1'b0));

  // p_high_fetch_r3
  p_high_fetch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(req_valid_i) && $past(req_fetch_i)
    && !$past(merge[req_addr_i[ADDR_W-1:DATA_SHIFT]])
    && ($past(req_addr_i[ADDR_W-1:PROG_SHIFT]) >= N_PROG)
    |-> (&ce_n_o && &pce_n_o));
endmodule

// File: tb/sim_cedec_top.sv
module sim_cedec_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, fetch = 1'b0, wr = 1'b0;
  logic [23:0] addr = '0;
  logic [7:0]  wmerge = '0;
  logic [7:0]  ce_n;
  logic [3:0]  pce_n;

  int vectors = 0, fails = 0, cycles = 0;
  int model_merge = 0;
  int exp_ce = 255, exp_pce = 15;
  string exp_tag = "R7";

  always #10 clk = ~clk;

  cedec_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_fetch_i(fetch),
    .req_addr_i(addr), .cfg_wr_i(wr), .cfg_merge_i(wmerge),
    .ce_n_o(ce_n), .pce_n_o(pce_n)
  );

  task automatic check_outputs();
    vectors++;
    if (int'(ce_n) != exp_ce || int'(pce_n) != exp_pce) begin
      fails++;
      $display("FAIL %s: ce_n=%02h pce_n=%01h expected ce_n=%02h pce_n=%01h",
               exp_tag, ce_n, pce_n, exp_ce, exp_pce);
    end
    if ($countones({~ce_n, ~pce_n}) > 1) begin
      fails++;
      $display("FAIL R6: ce_n=%02h pce_n=%01h expected at most one low", ce_n, pce_n);
    end
  endtask

  // Called at a falling edge: checks the last edge, then applies the next request.
  task automatic step(input bit v, input bit f, input int a, input bit w, input int m);
    int region, preg;
    @(negedge clk);
    check_outputs();
    valid = v; fetch = f; addr = 24'(a); wr = w; wmerge = 8'(m);
    region = (a >> 21) & 7;
    preg   = (a >> 20) & 15;
    exp_ce = 255; exp_pce = 15;
    if (!v) exp_tag = "R5";
    else if (!f) begin
      exp_ce  = 255 & ~(1 << region);
      exp_tag = (model_merge != 0) ? "R9" : "R1";
    end else if (((model_merge >> region) & 1) == 1) begin
      exp_ce  = 255 & ~(1 << region);
      exp_tag = "R4";
    end else if (preg < 4) begin
      exp_pce = 15 & ~(1 << preg);
      exp_tag = "R2";
    end else exp_tag = "R3";
    if (w) model_merge = m & 255;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: enables high during reset
    check_outputs();
    rst_n = 1'b1;
    // R7: merge bits cleared, fetch to 0 hits program enable 0
    step(1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    // R1: every data region
    for (int n = 0; n < 8; n++) step(1, 0, (n << 21) | 24'h1234, 0, 0);
    // R2, R3: all program nibbles without merging
    for (int p = 0; p < 16; p++) step(1, 1, (p << 20) | 24'h00abc, 0, 0);
    // R8: write in the same cycle as a fetch; the fetch uses the old bits
    step(1, 1, 24'h000010, 1, 8'h03);
    step(1, 1, 24'h100010, 0, 0);   // R4 via region 0 now merged
    step(1, 1, 24'h200010, 0, 0);   // R4 region 1
    step(1, 1, 24'h300010, 1, 8'h00);
    step(1, 1, 24'h300010, 0, 0);   // R8: back to program enable 3
    // R4 high regions merged; R9 data unaffected
    step(0, 0, 0, 1, 8'hf0);
    for (int n = 0; n < 8; n++) step(1, 1, (n << 21) | 24'h00077, 0, 0);
    for (int n = 0; n < 8; n++) step(1, 0, (n << 21) | 24'h00077, 0, 0);
    // R5: valid low with varied address
    for (int k = 0; k < 8; k++) step(0, k[0], k << 20, 0, 0);
    // random mix
    for (int k = 0; k < 4000; k++)
      step(($urandom % 5) != 0, $urandom % 2, $urandom % (1 << 24),
           ($urandom % 9) == 0, $urandom % 256);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check_outputs();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule